// File: doc/BRIEF.md
# Programmable Bus Wait-State Controller

This block decides how many bus-clock cycles each CPU bus access lasts. When a new access begins, the requester gives the decoded target region, the access direction and a start strobe. The block then holds `busy` high for the required number of cycles and raises `done` for one cycle on the last of them. The cycle count depends on the target region, on a 2-bit wait field for each external area, on whether the external bus runs in separate or multiplexed address/data mode, and, for internal memory, on a single wait bit.

An 8-bit wait-setting register holds the four external-area fields. It is loaded through a one-cycle write strobe and resets to all ones, so every external area starts at its slowest setting. Bus mode and the internal memory wait bit are static configuration inputs. They are sampled together with the region and direction when an access starts, so later changes cannot stretch or shorten an access that is already running.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset `busy` and `done` are 0 and the wait-setting register is 0xFF, so a separate-mode read of any external area lasts 4 cycles.
- R2: A write with `cfg_we`=1 loads `cfg_wdata` into the register. The field for external area i occupies bits 2i+1:2i.
- R3: In separate mode (`mux_mode`=0), an external field of 00 gives a 1-cycle read (`req_write`=0) and a 2-cycle write (`req_write`=1).
- R4: In separate mode, external fields 01, 10 and 11 give 2, 3 and 4 cycles for both reads and writes.
- R5: In multiplexed mode (`mux_mode`=1), external fields 00, 01 and 10 give 3 cycles and 11 gives 4 cycles, whatever the direction.
- R6: Region code 0 (internal special-function area) always takes 2 cycles. The unused codes 6 and 7 are handled the same way.
- R7: Region code 1 (internal ROM/RAM) takes 1 cycle when `int_mem_wait`=0 and 2 cycles when it is 1. Region codes 2 to 5 select external areas 0 to 3.
- R8: When a start is accepted at a clock edge, `busy` is high for exactly N consecutive cycles from that edge. `done` is high only in the last of those cycles.
- R9: `req_start` is ignored while `busy` is high. A start given in the cycle right after `done` is accepted.
- R10: Region, direction, bus mode, internal wait bit and the selected field are captured at the start. A register write or mode change during an access affects only later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the wait-setting register |
| cfg_wdata | input | 8 | Value written to the wait-setting register |
| req_start | input | 1 | Start strobe for a new access |
| req_region | input | 3 | Target region code (0 SFR, 1 ROM/RAM, 2-5 external 0-3) |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| mux_mode | input | 1 | 1 when the external bus is in multiplexed mode |
| int_mem_wait | input | 1 | Adds one wait to internal ROM/RAM accesses |
| busy | output | 1 | High while an access is in progress |
| done | output | 1 | One-cycle pulse on the final cycle of an access |

## Verification
The hardest situation to reach is an access whose settings change while it is running. The register is rewritten and the bus mode is flipped during `busy`, so that the new settings would give a different length if they were used. The stimulus starts a 4-cycle external access, performs a register write and a mode change in its second cycle, and checks that the running access still ends after 4 cycles and the next access follows the new settings. A second hard case is a start strobe held during `busy` followed by one given exactly in the cycle after `done`. It is reached by starting each access from the same falling edge on which the previous `busy` is first seen low.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam int FIELD_W  = 2;
  localparam int LEN_W    = 3;
  localparam int RG_SFR   = 0;
  localparam int RG_IMEM  = 1;
  localparam int RG_EXT0  = 2;

  // Cycle count of one external-area access
  function automatic logic [LEN_W-1:0] ext_cycles(
    input logic [FIELD_W-1:0] fld,
    input logic               wr,
    input logic               mux
  );
    if (mux)
      return (fld == 2'b11) ? LEN_W'(4) : LEN_W'(3);
    else if (fld == 2'b00)
      return wr ? LEN_W'(2) : LEN_W'(1);
    else
      return LEN_W'(fld) + LEN_W'(1);
  endfunction

  function automatic logic [LEN_W-1:0] imem_cycles(input logic wait_bit);
    return wait_bit ? LEN_W'(2) : LEN_W'(1);
  endfunction
endpackage

// File: rtl/wsc_cfg_reg.sv
module wsc_cfg_reg #(
  parameter int          REG_W   = 8,
  parameter logic [7:0]  RST_VAL = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  value <= REG_W'(RST_VAL);
    else if (we) value <= wdata;
  end
endmodule

// File: rtl/wsc_len_lut.sv
module wsc_len_lut
  import wsc_pkg::*;
#(
  parameter int NUM_EXT = 4,
  parameter int RGN_W   = 3,
  localparam int REG_W  = NUM_EXT * FIELD_W
) (
  input  logic [REG_W-1:0] cfg,
  input  logic [RGN_W-1:0] region,
  input  logic             wr,
  input  logic             mux,
  input  logic             imem_wait,
  output logic [LEN_W-1:0] len
);
  logic [FIELD_W-1:0] fld [NUM_EXT];

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_fld
    assign fld[g] = cfg[g*FIELD_W +: FIELD_W];
  end

  always_comb begin
    len = LEN_W'(2);  // special-function area and unused codes
    if (region == RGN_W'(RG_IMEM))
      len = imem_cycles(imem_wait);
    for (int i = 0; i < NUM_EXT; i++) begin
      if (region == RGN_W'(RG_EXT0 + i))
        len = ext_cycles(fld[i], wr, mux);
    end
  end
endmodule

// File: rtl/wsc_seq.sv
module wsc_seq #(
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             accept,
  output logic             busy,
  output logic             done
);
  logic [LEN_W-1:0] remain;

  assign busy   = (remain != '0);
  assign done   = (remain == LEN_W'(1));
  assign accept = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      remain <= '0;
    else if (accept) remain <= len;
    else if (busy)   remain <= remain - LEN_W'(1);
  end
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
  import wsc_pkg::*;
#(
  parameter int NUM_EXT = 4,
  parameter int RGN_W   = 3,
  localparam int REG_W  = NUM_EXT * FIELD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             req_start,
  input  logic [RGN_W-1:0] req_region,
  input  logic             req_write,
  input  logic             mux_mode,
  input  logic             int_mem_wait,
  output logic             busy,
  output logic             done
);
  logic [REG_W-1:0] cfg_q;
  logic [LEN_W-1:0] load_len;
  logic             accept;

  wsc_cfg_reg #(.REG_W(REG_W), .RST_VAL(8'hFF)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .value(cfg_q)
  );

  wsc_len_lut #(.NUM_EXT(NUM_EXT), .RGN_W(RGN_W)) u_lut (
    .cfg(cfg_q), .region(req_region), .wr(req_write), .mux(mux_mode),
    .imem_wait(int_mem_wait), .len(load_len)
  );

  wsc_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(req_start), .len(load_len),
    .accept(accept), .busy(busy), .done(done)
  );
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker
  import wsc_pkg::*;
#(
  parameter int RGN_W   = 3,
  parameter int NUM_EXT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept,
  input logic [LEN_W-1:0] load_len,
  input logic             busy,
  input logic             done,
  input logic             mux_mode,
  input logic [RGN_W-1:0] req_region
);
  logic [LEN_W-1:0] exp_len;
  logic [LEN_W-1:0] run_cnt;
  logic             is_ext;

  assign is_ext = (req_region >= RGN_W'(RG_EXT0)) &&
                  (req_region <  RGN_W'(RG_EXT0 + NUM_EXT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_len <= '0;
      run_cnt <= '0;
    end else if (accept) begin
      exp_len <= load_len;
      run_cnt <= '0;
    end else if (busy) begin
      run_cnt <= run_cnt + LEN_W'(1);
    end
  end

  AST_DONE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);                                              // R8
  AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);                                             // R8
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);                                   // R8
  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);                                            // R8
  AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy);                                           // R9
  AST_MUX_MINIMUM: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mux_mode && is_ext) |-> (load_len >= LEN_W'(3))); // R5
  AST_SFR_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_region == '0) |-> (load_len == LEN_W'(2)));   // R6
  AST_LEN_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (LEN_W'(run_cnt + LEN_W'(1)) == exp_len));          // R10
endmodule

bind bus_wait_ctrl wsc_checker #(.RGN_W(RGN_W), .NUM_EXT(NUM_EXT)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .load_len(load_len),
  .busy(busy), .done(done), .mux_mode(mux_mode), .req_region(req_region)
);

// File: tb/tb_bus_wait_ctrl.sv
module tb_bus_wait_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       cfg_we = 0;
  logic [7:0] cfg_wdata = '0;
  logic       req_start = 0;
  logic [2:0] req_region = '0;
  logic       req_write = 0;
  logic       mux_mode = 0;
  logic       int_mem_wait = 0;
  logic       busy, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  bus_wait_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_start(req_start), .req_region(req_region), .req_write(req_write),
    .mux_mode(mux_mode), .int_mem_wait(int_mem_wait), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Expected length restated as a table over the field value
  function automatic int model_len(int rgn, bit wr, bit mux, bit iw, logic [7:0] reg_v);
    int f;
    if (rgn == 1) return iw ? 2 : 1;
    if (rgn < 2 || rgn > 5) return 2;
    f = (reg_v >> (2 * (rgn - 2))) & 3;
    case ({mux, 2'(f)})
      3'b000:  return wr ? 2 : 1;
      3'b001:  return 2;
      3'b010:  return 3;
      3'b011:  return 4;
      3'b111:  return 4;
      default: return 3;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  // Counts busy cycles; called at the negedge right after the start edge
  task automatic measure(output int cnt, output int done_at, output int done_pulses);
    cnt = 0; done_at = -1; done_pulses = 0;
    while (busy && cnt < 20) begin
      cnt++;
      if (done) begin done_at = cnt; done_pulses++; end
      @(negedge clk);
    end
  endtask

  task automatic launch(int rgn, bit wr);
    req_region = 3'(rgn); req_write = wr; req_start = 1;
    @(negedge clk); req_start = 0;
  endtask

  task automatic run_access(string req, int rgn, bit wr, int exp);
    int cnt, dat, np;
    @(negedge clk);
    launch(rgn, wr);
    measure(cnt, dat, np);
    check(req, cnt, exp);
    check(req, dat, exp);
    check(req, np, 1);
  endtask

  task automatic t_reset();
    check("R1", int'(busy), 0);
    check("R1", int'(done), 0);
    mux_mode = 0;
    for (int a = 0; a < 4; a++) run_access("R1", 2 + a, 0, 4);
  endtask

  task automatic t_fields();
    cfg_write(8'b11_10_01_00);  // area0=00 area1=01 area2=10 area3=11
    mux_mode = 0;
    for (int a = 0; a < 4; a++) begin
      run_access("R2", 2 + a, 1, model_len(2 + a, 1, 0, 0, 8'b11100100));
    end
  endtask

  task automatic t_separate();
    mux_mode = 0;
    cfg_write(8'h00);
    run_access("R3", 2, 0, 1);
    run_access("R3", 5, 1, 2);
    for (int f = 1; f < 4; f++) begin
      cfg_write(8'(f << 2));
      run_access("R4", 3, 0, f + 1);
      run_access("R4", 3, 1, model_len(3, 1, 0, 0, 8'(f << 2)));
    end
  endtask

  task automatic t_mux();
    mux_mode = 1;
    for (int f = 0; f < 4; f++) begin
      cfg_write(8'(f << 4));
      run_access("R5", 4, 0, (f == 3) ? 4 : 3);
      run_access("R5", 4, 1, model_len(4, 1, 1, 0, 8'(f << 4)));
    end
    mux_mode = 0;
  endtask

  task automatic t_internal();
    int_mem_wait = 1; mux_mode = 1;
    run_access("R6", 0, 0, 2);
    run_access("R6", 6, 1, 2);
    run_access("R6", 7, 0, 2);
    int_mem_wait = 0;
    run_access("R7", 1, 0, 1);
    int_mem_wait = 1;
    run_access("R7", 1, 1, 2);
    int_mem_wait = 0; mux_mode = 0;
  endtask

  task automatic t_busy_start();
    int cnt, dat, np;
    cfg_write(8'hFF);
    @(negedge clk);
    launch(2, 0);  // 4 cycles
    req_region = 3'd1; req_start = 1;  // held during busy: must be ignored
    measure(cnt, dat, np);
    req_start = 0;
    check("R9", cnt, 4);
    check("R9", dat, 4);
    // start exactly in the cycle after done
    launch(1, 0);  // internal, 1 cycle
    measure(cnt, dat, np);
    check("R9", cnt, 1);
    check("R8", np, 1);
    check("R8", int'(busy), 0);
  endtask

  task automatic t_midchange();
    int cnt, dat, np;
    mux_mode = 0;
    cfg_write(8'hFF);
    @(negedge clk);
    launch(3, 0);  // area1 field 11: 4 cycles
    cnt = 1;
    cfg_we = 1; cfg_wdata = 8'h00; mux_mode = 1;
    @(negedge clk);
    cfg_we = 0; mux_mode = 0;
    measure(dat, np, np);
    check("R10", cnt + dat, 4);
    run_access("R10", 3, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_separate();
    t_mux();
    t_internal();
    t_busy_start();
    t_midchange();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule